// File: doc/BRIEF.md
# Die Over-Temperature Stage Monitor

This block watches a digitized die temperature, given in millidegrees Celsius on every clock cycle, and sorts it into one of four alarm stages (0 to 3). The three boundaries between stages are trip levels. A 2-bit threshold setting shifts all three levels together, and a fixed hysteresis band around each level keeps a noisy reading from toggling the stage. Each time the stage moves up or down, the block raises a one-cycle interrupt pulse. Software handles the pulse by reading the new stage.

Software reaches the block through a small register port. The write side is synchronous; the read side is combinational from the address. Through this port software can read two identification bytes, read the current stage, set the threshold, and switch the monitor on with a force-enable bit. While that bit is clear, the monitor reports stage 0 and stays silent.

Top module: `ovt_stage_alarm`

## Requirements
- R1: After reset the stage is 0, the threshold setting is 0, the force-enable bit is clear and `irq_pulse` is low.
- R2: Offset 0x04 reads 0x09 and offset 0x05 reads 0x08. Every other unmapped offset reads 0x00, and unused bits of mapped registers read 0. Writes to read-only or unmapped offsets change nothing.
- R3: The threshold setting is written and read at offset 0x40, bits [1:0]. The force-enable bit is written and read at offset 0x46, bit 7. A write takes effect from the next clock edge.
- R4: With threshold setting T, level k (k = 0, 1, 2) equals 105000 + 5000*T + 20000*k millidegrees.
- R5: When enabled at stage s < 3, the stage becomes s+1 on the next edge once the temperature is at least level s + 2000. The stage moves by at most one step per cycle.
- R6: When enabled at stage s > 0, the stage becomes s-1 on the next edge once the temperature is below level (s-1) - 2000.
- R7: A temperature inside the hysteresis band leaves the stage unchanged.
- R8: `irq_pulse` is high for exactly the one cycle in which a new stage first becomes visible. This holds for steps up and for steps down.
- R9: While force-enable is clear, the stage is 0 and no pulse is produced. Clearing the bit at a nonzero stage returns the stage to 0 on the following edge, also without a pulse.
- R10: Offset 0x08 reports the stage in bits [1:0]; bits [7:2] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| temp_mc | input | TEMP_W | Die temperature in millidegrees Celsius, unsigned |
| reg_addr | input | 8 | Register offset |
| reg_we | input | 1 | Write strobe for the offset on `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the offset on `reg_addr` |
| irq_pulse | output | 1 | One-cycle pulse on each stage change |

## Verification
The bench targets the exact edges of the hysteresis band: one millidegree below and exactly at a rise point, and exactly at and one below a fall point, for three threshold settings. A design with a wrong comparison sense, or one that drops the 2000 offset, steps one reading too early or too late. Sustained heat and sustained cold expose a design that jumps several stages in a single cycle, or that pulses only when the stage rises. Clearing the enable while at stage 3 catches a block that keeps its old stage or fires a spurious pulse as it returns to 0. Writes to the identification offsets, and reads of unmapped offsets, catch decode that aliases or leaks stored bits.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned NUM_LEVELS = 3;
  localparam int unsigned STAGE_W = 2;
  localparam int unsigned THR_W = 2;
  localparam int unsigned EN_BIT = 7;

  typedef logic [STAGE_W-1:0] stage_t;
  typedef logic [THR_W-1:0]   thr_t;

  localparam logic [REG_AW-1:0] OFS_ID_TYPE  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ID_SUB   = 8'h05;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_THRESH   = 8'h40;
  localparam logic [REG_AW-1:0] OFS_ALARM    = 8'h46;

  localparam logic [REG_DW-1:0] ID_TYPE_VAL  = 8'h09;
  localparam logic [REG_DW-1:0] ID_SUB_VAL   = 8'h08;
endpackage

// File: rtl/ovt_level_table.sv
module ovt_level_table
  import ovt_pkg::*;
#(
  parameter int TEMP_W        = 20,
  parameter int BASE_MC       = 105000,
  parameter int THR_STEP_MC   = 5000,
  parameter int STAGE_STEP_MC = 20000,
  parameter int HYST_MC       = 2000,
  localparam int LVL_W        = TEMP_W + 1
) (
  input  thr_t                                 thr,
  output logic [NUM_LEVELS-1:0][LVL_W-1:0]     rise_at,
  output logic [NUM_LEVELS-1:0][LVL_W-1:0]     fall_below
);
  logic [LVL_W-1:0] thr_offset;

  assign thr_offset = LVL_W'(thr) * LVL_W'(THR_STEP_MC);

  // One rise point and one fall point per level, both shifted by the threshold.
  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
    localparam int LEVEL_BASE = BASE_MC + k * STAGE_STEP_MC;
    assign rise_at[k]    = LVL_W'(LEVEL_BASE + HYST_MC) + thr_offset;
    assign fall_below[k] = LVL_W'(LEVEL_BASE - HYST_MC) + thr_offset;
  end
endmodule

// File: rtl/ovt_stage_tracker.sv
module ovt_stage_tracker
  import ovt_pkg::*;
#(
  parameter int TEMP_W = 20,
  localparam int LVL_W = TEMP_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic [TEMP_W-1:0]                 temp_mc,
  input  logic [NUM_LEVELS-1:0][LVL_W-1:0]  rise_at,
  input  logic [NUM_LEVELS-1:0][LVL_W-1:0]  fall_below,
  output stage_t                            stage_q,
  output logic                              irq_q
);
  logic [LVL_W-1:0] temp_ext;
  logic [LVL_W-1:0] rise_sel;
  logic [LVL_W-1:0] fall_sel;
  logic             go_up;
  logic             go_down;
  stage_t           stage_nxt;
  logic             stage_ld;
  logic             irq_nxt;

  assign temp_ext = {1'b0, temp_mc};

  // Pick the level above and the level below the present stage.
  always_comb begin
    unique case (stage_q)
      2'd0:    begin rise_sel = rise_at[0]; fall_sel = fall_below[0]; end
      2'd1:    begin rise_sel = rise_at[1]; fall_sel = fall_below[0]; end
      2'd2:    begin rise_sel = rise_at[2]; fall_sel = fall_below[1]; end
      default: begin rise_sel = rise_at[2]; fall_sel = fall_below[2]; end
    endcase
  end

  always_comb begin
    go_up     = (stage_q != 2'd3) && (temp_ext >= rise_sel);
    go_down   = (stage_q != 2'd0) && (temp_ext <  fall_sel);
    stage_nxt = stage_q;
    if (!enable)      stage_nxt = 2'd0;
    else if (go_up)   stage_nxt = stage_q + 2'd1;
    else if (go_down) stage_nxt = stage_q - 2'd1;
    stage_ld = (stage_nxt != stage_q);
    irq_nxt  = enable && stage_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'd0;
    end else if (stage_ld) begin
      stage_q <= stage_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && stage_q != $past(stage_q)) |->
      (({1'b0, stage_q} == {1'b0, $past(stage_q)} + 3'd1) ||
       ({1'b0, stage_q} + 3'd1 == {1'b0, $past(stage_q)})));

  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q > $past(stage_q)) |-> ($past(temp_ext) >= $past(rise_sel)));

  assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && stage_q < $past(stage_q)) |-> ($past(temp_ext) < $past(fall_sel)));

  assert_irq_means_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (stage_q != $past(stage_q)));

  assert_change_means_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && stage_q != $past(stage_q)) |-> irq_q);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (stage_q == 2'd0 && !irq_q));
endmodule

// File: rtl/ovt_reg_bank.sv
module ovt_reg_bank
  import ovt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              we,
  input  logic [REG_DW-1:0] wdata,
  input  stage_t            stage,
  output thr_t              thr_q,
  output logic              en_q,
  output logic [REG_DW-1:0] rdata
);
  thr_t thr_nxt;
  logic thr_ld;
  logic en_nxt;
  logic en_ld;

  always_comb begin
    thr_ld  = we && (addr == OFS_THRESH);
    thr_nxt = wdata[THR_W-1:0];
    en_ld   = we && (addr == OFS_ALARM);
    en_nxt  = wdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_ld) begin
      thr_q <= thr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ld) begin
      en_q <= en_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_ID_TYPE: rdata = ID_TYPE_VAL;
      OFS_ID_SUB:  rdata = ID_SUB_VAL;
      OFS_STATUS:  rdata[STAGE_W-1:0] = stage;
      OFS_THRESH:  rdata[THR_W-1:0] = thr_q;
      OFS_ALARM:   rdata[EN_BIT] = en_q;
      default:     rdata = '0;
    endcase
  end

  assert_id_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_ID_TYPE) |-> (rdata == 8'h09));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFS_ID_TYPE && addr != OFS_ID_SUB && addr != OFS_STATUS &&
     addr != OFS_THRESH && addr != OFS_ALARM) |-> (rdata == 8'h00));

  assert_thr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_THRESH) |=> (thr_q == $past(wdata[1:0])));

  assert_en_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_ALARM) |=> (en_q == $past(wdata[7])));

  assert_wdata_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(wdata));
endmodule

// File: rtl/ovt_stage_alarm.sv
module ovt_stage_alarm
  import ovt_pkg::*;
#(
  parameter int TEMP_W        = 20,
  parameter int BASE_MC       = 105000,
  parameter int THR_STEP_MC   = 5000,
  parameter int STAGE_STEP_MC = 20000,
  parameter int HYST_MC       = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_mc,
  input  logic [7:0]        reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_pulse
);
  localparam int LVL_W = TEMP_W + 1;

  logic [1:0]                        rst_sync_q;
  logic                              rst_core_n;
  thr_t                              thr;
  logic                              enable;
  stage_t                            stage;
  logic [NUM_LEVELS-1:0][LVL_W-1:0]  rise_at;
  logic [NUM_LEVELS-1:0][LVL_W-1:0]  fall_below;

  // Asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ovt_reg_bank u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .addr  (reg_addr),
    .we    (reg_we),
    .wdata (reg_wdata),
    .stage (stage),
    .thr_q (thr),
    .en_q  (enable),
    .rdata (reg_rdata)
  );

  ovt_level_table #(
    .TEMP_W        (TEMP_W),
    .BASE_MC       (BASE_MC),
    .THR_STEP_MC   (THR_STEP_MC),
    .STAGE_STEP_MC (STAGE_STEP_MC),
    .HYST_MC       (HYST_MC)
  ) u_levels (
    .thr        (thr),
    .rise_at    (rise_at),
    .fall_below (fall_below)
  );

  ovt_stage_tracker #(
    .TEMP_W (TEMP_W)
  ) u_tracker (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable     (enable),
    .temp_mc    (temp_mc),
    .rise_at    (rise_at),
    .fall_below (fall_below),
    .stage_q    (stage),
    .irq_q      (irq_pulse)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    (!rst_core_n) |=> (!irq_pulse && stage == 2'd0));
endmodule

// File: tb/ovt_stage_alarm_bench.sv
`timescale 1ns/1ps
module ovt_stage_alarm_bench;
  localparam int TEMP_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TEMP_W-1:0] temp_mc = '0;
  logic [7:0]        reg_addr = 8'h08;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_wdata = 8'h00;
  logic [7:0]        reg_rdata;
  logic              irq_pulse;

  always #2.5 clk = ~clk;

  ovt_stage_alarm #(.TEMP_W(TEMP_W)) u_ovt_stage_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .temp_mc   (temp_mc),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_pulse (irq_pulse)
  );

  typedef struct {
    int    stg;
    bit    irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   m_thr = 0;
  int   m_stage = 0;
  bit   m_en = 1'b0;
  bit   done = 1'b0;

  function automatic int level(int k);
    return 105000 + 5000 * m_thr + 20000 * k;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, drives one reading, queues the result
  // expected after the next rising edge, and returns at the next falling edge.
  task automatic tick(int t, string tag);
    exp_t it;
    int   nxt;
    temp_mc  = TEMP_W'(t);
    reg_addr = 8'h08;
    reg_we   = 1'b0;
    nxt = m_stage;
    if (!m_en)                                      nxt = 0;
    else if (m_stage < 3 && t >= level(m_stage) + 2000) nxt = m_stage + 1;
    else if (m_stage > 0 && t < level(m_stage - 1) - 2000) nxt = m_stage - 1;
    it.stg = nxt;
    it.irq = m_en && (nxt != m_stage);
    it.tag = tag;
    m_stage = nxt;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'h40) m_thr = int'(d[1:0]);
    if (a == 8'h46) m_en = d[7];
  endtask

  task automatic rd(logic [7:0] a, int exp, string tag);
    reg_addr = a;
    #0.5;
    check(tag, int'(reg_rdata), exp);
  endtask

  // Monitor: compares queued expectations shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " status"}, int'(reg_rdata), it.stg);
        check({it.tag, " irq"}, int'(irq_pulse), int'(it.irq));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h08, 0, "R1 stage");
    rd(8'h40, 0, "R1 thresh");
    rd(8'h46, 0, "R1 enable");
    check("R1 irq", int'(irq_pulse), 0);

    // R2 identification and decode
    rd(8'h04, 8'h09, "R2 type");
    rd(8'h05, 8'h08, "R2 subtype");
    wr(8'h04, 8'h55);
    rd(8'h04, 8'h09, "R2 write to id ignored");
    rd(8'h00, 0, "R2 unmapped 0x00");
    rd(8'h41, 0, "R2 unmapped 0x41");

    // R3 control registers
    wr(8'h40, 8'hFF);
    rd(8'h40, 3, "R3 thresh bits");
    wr(8'h46, 8'hFF);
    rd(8'h46, 8'h80, "R3 enable bit");
    rd(8'h47, 0, "R2 unmapped 0x47");

    // R9 disabled: hot but silent
    wr(8'h46, 8'h00);
    for (int i = 0; i < 3; i++) tick(300000, "R9 disabled");

    // R5 and R8 climbing, threshold 0
    wr(8'h40, 8'h00);
    wr(8'h46, 8'h80);
    for (int i = 0; i < 4; i++) tick(300000, "R5 R8 climb");

    // R6 and R8 cooling
    for (int i = 0; i < 4; i++) tick(30000, "R6 R8 cool");

    // R4 and R7 boundaries, threshold 0
    tick(106999, "R7 below rise0");
    tick(107000, "R4 at rise0");
    tick(103000, "R7 at fall0");
    tick(102999, "R6 below fall0");

    // Threshold 2
    wr(8'h40, 8'h02);
    tick(116999, "R4 thr2 below rise0");
    tick(117000, "R4 thr2 at rise0");
    tick(137000, "R4 thr2 at rise1");
    tick(133000, "R7 thr2 at fall1");
    tick(132999, "R6 thr2 below fall1");
    tick(10000, "R6 thr2 cold");

    // Threshold 3, top level
    wr(8'h40, 8'h03);
    tick(142000, "R4 thr3 rise0");
    tick(142000, "R4 thr3 rise1");
    tick(161999, "R7 thr3 below rise2");
    tick(162000, "R4 thr3 at rise2");
    tick(300000, "R5 saturate");
    rd(8'h08, 3, "R10 status at stage3");

    // R9 disabling at stage 3
    wr(8'h46, 8'h00);
    tick(300000, "R9 disable drop");
    tick(300000, "R9 stays zero");
    rd(8'h46, 0, "R3 enable cleared");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule